// File: doc/BRIEF.md
# Program Memory Lock Protection Unit

This block keeps the three one-way protection bits of an on-chip code store and turns them into a protection level. From that level it produces the permission signals that the rest of a microcontroller consults. Each bit starts erased. A single program pulse in lock-write mode sets one bit. Only a whole-array erase returns the bits to the erased state. The bit values are never driven onto any output. Software and test equipment can learn the level only from which permissions are withheld.

The level rises with each added restriction, and each level keeps the restrictions of the one below it. At the open level every request is granted. The second level stops table reads issued from external code from seeing internal code bytes, and it blocks further code programming. The third level also refuses verify reads. The fourth level also forbids fetching instructions from external memory.

The external-access strap has two behaviours. At the open level the effective value follows the pin combinationally. At any higher level the block uses a copy of the pin that is captured while device reset is asserted. That copy then holds until the next reset.

Top module: `lock_guard`

## Requirements
- R1: When all lock bits are erased (level 1), each of the four grant outputs equals its request input, so all requests are granted.
- R2: A one-cycle `lock_wr` pulse programs the bit chosen by `lock_sel`, where 1 selects the first bit, 2 the second and 3 the third. The new level governs the grants from the clock edge that captures the pulse. `lock_sel` = 0 programs nothing.
- R3: The level is set by the highest programmed bit. Third bit programmed gives level 4, else second bit gives level 3, else first bit gives level 2, else level 1. This holds for combinations with gaps as well.
- R4: At level 2 and above, `movc_int_grant` and `code_prog_grant` are 0 whatever the requests.
- R5: At level 3 and above, `verify_grant` is 0.
- R6: At level 4, `ext_fetch_grant` is 0. At levels 1 to 3 it equals `ext_fetch_req`.
- R7: At level 2 and above, `ea_eff` equals the value `ea_pin` had on the last clock edge with `rst_n` low. Changes of `ea_pin` outside reset do not affect it.
- R8: At level 1, `ea_eff` follows `ea_pin` combinationally, in the same cycle.
- R9: Device reset (`rst_n` low) never clears a lock bit. Lock bits can still be programmed at every level, so the level can only go up until an erase.
- R10: An `erase` pulse clears all lock bits on the next edge and returns the block to level 1. When `erase` and `lock_wr` occur in the same cycle, the erase wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low device reset; strap sampling window |
| lock_wr | input | 1 | One-cycle lock-bit program pulse |
| lock_sel | input | 2 | Bit to program: 1, 2 or 3; 0 selects none |
| erase | input | 1 | One-cycle whole-array erase pulse, clears every lock bit |
| ea_pin | input | 1 | Live level of the external-access strap pin |
| movc_ext_req | input | 1 | Table read of internal code issued from external code |
| verify_req | input | 1 | Verify read of the code array |
| ext_fetch_req | input | 1 | Instruction fetch from external memory |
| code_prog_req | input | 1 | Code byte program request |
| movc_int_grant | output | 1 | Permission for the external-code table read |
| verify_grant | output | 1 | Permission for the verify read |
| ext_fetch_grant | output | 1 | Permission for the external fetch |
| code_prog_grant | output | 1 | Permission for code programming |
| ea_eff | output | 1 | Effective external-access value |

## Verification
The bench programs bits with gaps, such as only the third bit or only the second. A decoder that demands the bits in order would leave the part unprotected there. It checks that reset leaves the lock bits alone. A design that reset them would drop its protection on every power cycle. It also checks that the strap copy ignores the pin after reset. A design that followed the pin at a locked level would let an attacker switch to external execution. Finally it checks that an erase wins over a simultaneous lock write, because a design that let the write win would leave a stray protected bit after erasing.

// File: rtl/lockp_pkg.sv
// Shared definitions of the lock protection unit.
// Assumes three lock bits and four cumulative levels.
package lockp_pkg;
    localparam int LOCK_BITS = 3;
    localparam int LVL_W     = $clog2(LOCK_BITS + 1);

    typedef enum logic [LVL_W-1:0] {
        PL_OPEN     = 2'd0,  // level 1
        PL_NOXREAD  = 2'd1,  // level 2
        PL_NOVERIFY = 2'd2,  // level 3
        PL_NOEXT    = 2'd3   // level 4
    } prot_level_t;
endpackage

// File: rtl/lock_cells.sv
// One-way lock bit storage and level decode.
// The bits model nonvolatile cells: they start erased, are set one at a
// time by a program pulse and are cleared only by erase. Device reset
// does not touch them. The level comes from the highest programmed bit.
module lock_cells
    import lockp_pkg::*;
#(
    parameter int NBITS = LOCK_BITS,
    localparam int SEL_W = $clog2(NBITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_wr,
    input  logic [SEL_W-1:0] lock_sel,
    input  logic             erase,
    output prot_level_t      level
);
    logic [NBITS-1:0] cells_q = '0;
    logic [NBITS-1:0] set_vec;

    // one-hot set vector for the selected bit (select 0 sets nothing)
    always_comb begin
        set_vec = '0;
        for (int i = 0; i < NBITS; i++)
            if (lock_wr && (int'(lock_sel) == i + 1)) set_vec[i] = 1'b1;
    end

    // cell update: erase has priority, programming only sets bits
    always_ff @(posedge clk) begin
        if (erase) cells_q <= '0;
        else       cells_q <= cells_q | set_vec;
    end

    // level decode: highest programmed bit wins
    always_comb begin
        level = PL_OPEN;
        for (int i = 0; i < NBITS; i++)
            if (cells_q[i]) level = prot_level_t'(i + 1);
    end

    // R9
    cells_one_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(erase) |-> (($past(cells_q) & ~cells_q) == '0));
    // R10
    erase_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> (level == PL_OPEN));
endmodule

// File: rtl/ea_capture.sv
// External-access strap handling.
// Samples the pin on every clock edge while reset is low. At the open
// level the pin passes straight through; above it the held copy is used.
module ea_capture
    import lockp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ea_pin,
    input  prot_level_t level,
    output logic        ea_eff
);
    logic ea_hold_q;

    // capture the strap only inside the reset window
    always_ff @(posedge clk) begin
        if (!rst_n) ea_hold_q <= ea_pin;
    end

    // choose the live pin or the held copy
    always_comb ea_eff = (level == PL_OPEN) ? ea_pin : ea_hold_q;

    // R7
    ea_locked_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && level != PL_OPEN && $past(level) != PL_OPEN)
        |-> $stable(ea_eff));
endmodule

// File: rtl/access_gate.sv
// Permission gating by protection level.
// Each grant is its request masked by the levels that forbid it.
// Assumes requests are already qualified by the caller.
module access_gate
    import lockp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  prot_level_t level,
    input  logic        movc_ext_req,
    input  logic        verify_req,
    input  logic        ext_fetch_req,
    input  logic        code_prog_req,
    output logic        movc_int_grant,
    output logic        verify_grant,
    output logic        ext_fetch_grant,
    output logic        code_prog_grant
);
    logic lvl_ge2, lvl_ge3, lvl_ge4;

    // cumulative level flags
    always_comb begin
        lvl_ge2 = (level >= PL_NOXREAD);
        lvl_ge3 = (level >= PL_NOVERIFY);
        lvl_ge4 = (level == PL_NOEXT);
    end

    // grant masking
    always_comb begin
        movc_int_grant  = movc_ext_req  & ~lvl_ge2;
        code_prog_grant = code_prog_req & ~lvl_ge2;
        verify_grant    = verify_req    & ~lvl_ge3;
        ext_fetch_grant = ext_fetch_req & ~lvl_ge4;
    end

    // R4
    locked_no_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level != PL_OPEN) |-> (!code_prog_grant && !movc_int_grant));
    // R5
    no_verify_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == PL_NOVERIFY || level == PL_NOEXT) |-> !verify_grant);
    // R6
    no_ext_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == PL_NOEXT) |-> !ext_fetch_grant);
    // R1
    open_grants_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == PL_OPEN) |-> ($countones({movc_int_grant, verify_grant,
            ext_fetch_grant, code_prog_grant}) ==
            $countones({movc_ext_req, verify_req, ext_fetch_req, code_prog_req})));
endmodule

// File: rtl/lock_guard.sv
// Top of the program memory lock protection unit.
// Ties the lock cells, the strap capture and the permission gate together.
// Assumes the erase and lock-write pulses are one cycle wide.
module lock_guard
    import lockp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lock_wr,
    input  logic [1:0] lock_sel,
    input  logic       erase,
    input  logic       ea_pin,
    input  logic       movc_ext_req,
    input  logic       verify_req,
    input  logic       ext_fetch_req,
    input  logic       code_prog_req,
    output logic       movc_int_grant,
    output logic       verify_grant,
    output logic       ext_fetch_grant,
    output logic       code_prog_grant,
    output logic       ea_eff
);
    prot_level_t level;

    lock_cells #(.NBITS(LOCK_BITS)) u_cells (
        .clk(clk), .rst_n(rst_n), .lock_wr(lock_wr), .lock_sel(lock_sel),
        .erase(erase), .level(level)
    );

    ea_capture u_ea (
        .clk(clk), .rst_n(rst_n), .ea_pin(ea_pin), .level(level), .ea_eff(ea_eff)
    );

    access_gate u_gate (
        .clk(clk), .rst_n(rst_n), .level(level),
        .movc_ext_req(movc_ext_req), .verify_req(verify_req),
        .ext_fetch_req(ext_fetch_req), .code_prog_req(code_prog_req),
        .movc_int_grant(movc_int_grant), .verify_grant(verify_grant),
        .ext_fetch_grant(ext_fetch_grant), .code_prog_grant(code_prog_grant)
    );

    // R8
    open_ea_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == PL_OPEN) |-> (ea_eff == ea_pin));
endmodule

// File: tb/sim_lock_guard.sv
// Directed bench for lock_guard: one task per scenario.
module sim_lock_guard;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lock_wr = 1'b0, erase = 1'b0, ea_pin = 1'b0;
    logic [1:0] lock_sel = 2'd0;
    logic movc_ext_req = 1'b0, verify_req = 1'b0, ext_fetch_req = 1'b0, code_prog_req = 1'b0;
    logic movc_int_grant, verify_grant, ext_fetch_grant, code_prog_grant, ea_eff;
    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    lock_guard u0 (
        .clk(clk), .rst_n(rst_n), .lock_wr(lock_wr), .lock_sel(lock_sel),
        .erase(erase), .ea_pin(ea_pin), .movc_ext_req(movc_ext_req),
        .verify_req(verify_req), .ext_fetch_req(ext_fetch_req),
        .code_prog_req(code_prog_req), .movc_int_grant(movc_int_grant),
        .verify_grant(verify_grant), .ext_fetch_grant(ext_fetch_grant),
        .code_prog_grant(code_prog_grant), .ea_eff(ea_eff)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // expected grants {movc, verify, ext, prog} with all requests high, by level 1..4
    function automatic logic [3:0] grants_for(input int lvl);
        case (lvl)
            1: return 4'b1111;
            2: return 4'b0110;
            3: return 4'b0010;
            default: return 4'b0000;
        endcase
    endfunction

    task automatic probe(input string req, input logic [3:0] reqs, input logic [3:0] exp);
        {movc_ext_req, verify_req, ext_fetch_req, code_prog_req} = reqs;
        #1;
        check(req, {movc_int_grant, verify_grant, ext_fetch_grant, code_prog_grant}, exp);
    endtask

    task automatic pulse_lock(input logic [1:0] sel);
        @(negedge clk); lock_wr = 1'b1; lock_sel = sel;
        @(negedge clk); lock_wr = 1'b0; lock_sel = 2'd0;
    endtask

    task automatic pulse_erase();
        @(negedge clk); erase = 1'b1;
        @(negedge clk); erase = 1'b0;
    endtask

    task automatic do_reset(input int cycles);
        @(negedge clk); rst_n = 1'b0;
        repeat (cycles) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_open();
        pulse_erase();
        probe("R1", 4'b1111, 4'b1111);
        probe("R1", 4'b1010, 4'b1010);
        probe("R1", 4'b0101, 4'b0101);
    endtask

    task automatic t_program_steps();
        pulse_erase();
        pulse_lock(2'd0);
        probe("R2", 4'b1111, grants_for(1));
        pulse_lock(2'd1);
        probe("R2", 4'b1111, grants_for(2));
        probe("R4", 4'b1001, 4'b0000);
        pulse_lock(2'd2);
        probe("R5", 4'b1111, grants_for(3));
        pulse_lock(2'd3);
        probe("R6", 4'b1111, grants_for(4));
    endtask

    task automatic t_gaps();
        pulse_erase();
        pulse_lock(2'd3);
        probe("R3", 4'b1111, grants_for(4));
        pulse_erase();
        pulse_lock(2'd2);
        probe("R3", 4'b1111, grants_for(3));
        probe("R6", 4'b0010, 4'b0010);
    endtask

    task automatic t_ea();
        pulse_erase();
        pulse_lock(2'd1);
        ea_pin = 1'b1;
        do_reset(2);
        ea_pin = 1'b0; #1;
        check("R7", {3'b0, ea_eff}, 4'b0001);
        @(negedge clk); ea_pin = 1'b1; @(negedge clk); ea_pin = 1'b0; #1;
        check("R7", {3'b0, ea_eff}, 4'b0001);
        ea_pin = 1'b0;
        do_reset(1);
        ea_pin = 1'b1; #1;
        check("R7", {3'b0, ea_eff}, 4'b0000);
        pulse_erase();
        ea_pin = 1'b0; #1;
        check("R8", {3'b0, ea_eff}, 4'b0000);
        ea_pin = 1'b1; #1;
        check("R8", {3'b0, ea_eff}, 4'b0001);
    endtask

    task automatic t_reset_keeps();
        pulse_erase();
        pulse_lock(2'd1);
        pulse_lock(2'd2);
        do_reset(3);
        probe("R9", 4'b1111, grants_for(3));
        pulse_lock(2'd3);
        probe("R9", 4'b1111, grants_for(4));
    endtask

    task automatic t_erase_priority();
        pulse_erase();
        pulse_lock(2'd2);
        @(negedge clk); erase = 1'b1; lock_wr = 1'b1; lock_sel = 2'd3;
        @(negedge clk); erase = 1'b0; lock_wr = 1'b0; lock_sel = 2'd0;
        probe("R10", 4'b1111, grants_for(1));
    endtask

    initial begin
        #(8 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_open();
        t_program_steps();
        t_gaps();
        t_ea();
        t_reset_keeps();
        t_erase_priority();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule